// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block sequences power for a chip that can be put to sleep and woken from a pin. It runs on the slow always-on clock (nominally 32.768 kHz). Software starts a power-down by writing a command register. The block then drops its power-enable output and watches an active-low wakeup pin. The pin must stay asserted without a break for a programmable minimum time before the block restores power. Once power is back, the block keeps a system reset output low for a second programmable time and then releases it.

Both times are set through registers. Each register keeps only its upper field, so both times step in units of 32 slow-clock ticks. With the defaults, the wakeup filter is about 100 ms and the reset hold about 60 ms. A short glitch on the wakeup pin sends the block back to sleep, and the filter count then starts again from zero. The wakeup pin passes through a configurable synchronizer before the sequencer sees it.

Top module: `hib_wake_seq`

## Requirements
- R1: After reset, pwr_en and sys_rst_n are both 1. The filter register reads 0x0000_0CC0 (field 102) and the reset-hold register reads 0x0000_07A0 (field 61).
- R2: The filter register sits at offset 0x24 and keeps its field F in bits 15:5. The reset-hold register sits at offset 0x28 and keeps its field H in bits 11:5. All other bits of these two registers read 0. The command register at 0x20 reads 0, and so does any unmapped offset.
- R3: In the running state, a write to 0x20 with data bit 0 set makes pwr_en and sys_rst_n both 0 from the next cycle. The same write with bit 0 clear has no effect.
- R4: The wakeup pin passes through SYNC_STAGES flops (default 2). Wakeup is accepted after max(F*32,1) consecutive asserted samples. pwr_en rises SYNC_STAGES + max(F*32,1) cycles after the pin goes low while asleep.
- R5: If the pin deasserts before the filter time is complete, power stays off and the filter count restarts from zero at the next assertion.
- R6: After pwr_en rises, sys_rst_n stays low for max(H*32,1) cycles and then goes high. H=0 releases reset on the next tick.
- R7: Activity on the wakeup pin while running does not affect the outputs. A hibernate command while asleep, filtering or holding reset is ignored.
- R8: Whenever pwr_en is 0, sys_rst_n is also 0.
- R9: If the pin is already asserted when the hibernate command is taken, filtering starts on the next cycle. pwr_en then rises max(F*32,1) cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write offset |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read offset |
| rd_data | output | DATA_W | Register read data (combinational) |
| wake_n | input | 1 | Active-low wakeup pin |
| pwr_en | output | 1 | Power-enable, high while running or holding reset |
| sys_rst_n | output | 1 | Active-low system reset, high only while running |

## Verification
The hibernate command and the wakeup filter can act in the same cycle. This happens when the pin is already held low at the moment the command is accepted. The bench holds the pin asserted while the block is running, issues the command, and counts the cycles from the write edge to the rise of pwr_en. That count must equal max(F*32,1), which shows that the first sample is taken on the cycle right after entry and that no sample is lost or counted twice. A second overlap is a command issued in the middle of filtering. The bench checks that this command does not disturb the wakeup latency.

// File: rtl/hib_wake_pkg.sv
package hib_wake_pkg;
   typedef enum logic [1:0] {
      PS_RUN     = 2'd0,
      PS_SLEEP   = 2'd1,
      PS_QUALIFY = 2'd2,
      PS_RESET   = 2'd3
   } pwr_state_e;
endpackage

// File: rtl/hib_wake_sync.sv
module hib_wake_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wake_n,
   output logic wake_act
);
   generate
      if (STAGES == 0) begin : g_direct
         assign wake_act = ~wake_n;
      end else if (STAGES == 1) begin : g_one
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= 1'b1;
            else        stage_q <= wake_n;
         end
         assign wake_act = ~stage_q;
      end else begin : g_chain
         logic [STAGES-1:0] pipe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[STAGES-2:0], wake_n};
         end
         assign wake_act = ~pipe_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hib_wake_regs.sv
module hib_wake_regs #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter logic [ADDR_W-1:0] CMD_OFS  = 8'h20,
   parameter logic [ADDR_W-1:0] FILT_OFS = 8'h24,
   parameter logic [ADDR_W-1:0] HOLD_OFS = 8'h28,
   parameter int FILT_LSB  = 5,
   parameter int FILT_HI   = 15,
   parameter int HOLD_LSB  = 5,
   parameter int HOLD_HI   = 11,
   parameter int FILT_INIT = 102,
   parameter int HOLD_INIT = 61,
   localparam int FW = FILT_HI - FILT_LSB + 1,
   localparam int HW = HOLD_HI - HOLD_LSB + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [FW-1:0]     filt_field,
   output logic [HW-1:0]     hold_field,
   output logic              hib_req
);
   logic [FW-1:0] filt_q;
   logic [HW-1:0] hold_q;
   logic          unused_wr_bits;

   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= FW'(FILT_INIT);
         hold_q <= HW'(HOLD_INIT);
      end else if (wr_en) begin
         if (wr_addr == FILT_OFS) filt_q <= wr_data[FILT_HI:FILT_LSB];
         if (wr_addr == HOLD_OFS) hold_q <= wr_data[HOLD_HI:HOLD_LSB];
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == FILT_OFS) rd_data[FILT_HI:FILT_LSB] = filt_q;
      if (rd_addr == HOLD_OFS) rd_data[HOLD_HI:HOLD_LSB] = hold_q;
   end

   assign hib_req    = wr_en && (wr_addr == CMD_OFS) && wr_data[0];
   assign filt_field = filt_q;
   assign hold_field = hold_q;
endmodule

// File: rtl/hib_wake_fsm.sv
module hib_wake_fsm
   import hib_wake_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hib_req,
   input  logic          wake_act,
   input  logic [CW-1:0] filt_ticks,
   input  logic [CW-1:0] hold_ticks,
   output logic          pwr_en,
   output logic          sys_rst_n
);
   pwr_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic [CW:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_RUN;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            PS_RUN: begin
               cnt_q <= '0;
               if (hib_req) state_q <= PS_SLEEP;
            end
            PS_SLEEP, PS_QUALIFY: begin
               if (!wake_act) begin
                  state_q <= PS_SLEEP;
                  cnt_q   <= '0;
               end else if (cnt_inc >= {1'b0, filt_ticks}) begin
                  state_q <= PS_RESET;
                  cnt_q   <= '0;
               end else begin
                  state_q <= PS_QUALIFY;
                  cnt_q   <= cnt_inc[CW-1:0];
               end
            end
            PS_RESET: begin
               if (cnt_inc >= {1'b0, hold_ticks}) begin
                  state_q <= PS_RUN;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_inc[CW-1:0];
               end
            end
            default: begin
               state_q <= PS_RUN;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign pwr_en    = (state_q == PS_RUN) || (state_q == PS_RESET);
   assign sys_rst_n = (state_q == PS_RUN);
endmodule

// File: rtl/hib_wake_seq.sv
module hib_wake_seq #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter logic [ADDR_W-1:0] CMD_OFS  = 8'h20,
   parameter logic [ADDR_W-1:0] FILT_OFS = 8'h24,
   parameter logic [ADDR_W-1:0] HOLD_OFS = 8'h28,
   parameter int FILT_LSB    = 5,
   parameter int FILT_HI     = 15,
   parameter int HOLD_LSB    = 5,
   parameter int HOLD_HI     = 11,
   parameter int FILT_INIT   = 102,
   parameter int HOLD_INIT   = 61,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wake_n,
   output logic              pwr_en,
   output logic              sys_rst_n
);
   localparam int FW = FILT_HI - FILT_LSB + 1;
   localparam int HW = HOLD_HI - HOLD_LSB + 1;
   localparam int CW = ((FILT_HI > HOLD_HI) ? FILT_HI : HOLD_HI) + 1;

   generate
      if (FILT_HI >= DATA_W || FILT_LSB > FILT_HI || FILT_LSB < 1) begin : g_bad_filt
         $error("filter field does not fit the data word");
      end
      if (HOLD_HI >= DATA_W || HOLD_LSB > HOLD_HI || HOLD_LSB < 1) begin : g_bad_hold
         $error("reset-hold field does not fit the data word");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
      if (CMD_OFS == FILT_OFS || CMD_OFS == HOLD_OFS || FILT_OFS == HOLD_OFS) begin : g_bad_map
         $error("register offsets must differ");
      end
   endgenerate

   logic [FW-1:0] filt_field;
   logic [HW-1:0] hold_field;
   logic          hib_req;
   logic          wake_act;
   logic [CW-1:0] filt_ticks;
   logic [CW-1:0] hold_ticks;

   hib_wake_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .CMD_OFS(CMD_OFS), .FILT_OFS(FILT_OFS), .HOLD_OFS(HOLD_OFS),
      .FILT_LSB(FILT_LSB), .FILT_HI(FILT_HI),
      .HOLD_LSB(HOLD_LSB), .HOLD_HI(HOLD_HI),
      .FILT_INIT(FILT_INIT), .HOLD_INIT(HOLD_INIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .filt_field(filt_field), .hold_field(hold_field),
      .hib_req(hib_req)
   );

   hib_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .wake_n(wake_n), .wake_act(wake_act)
   );

   assign filt_ticks = CW'(filt_field) << FILT_LSB;
   assign hold_ticks = CW'(hold_field) << HOLD_LSB;

   hib_wake_fsm #(.CW(CW)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .hib_req(hib_req), .wake_act(wake_act),
      .filt_ticks(filt_ticks), .hold_ticks(hold_ticks),
      .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
   );
endmodule

// File: rtl/hib_wake_seq_chk.sv
module hib_wake_seq_chk #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter logic [ADDR_W-1:0] CMD_OFS  = 8'h20,
   parameter logic [ADDR_W-1:0] FILT_OFS = 8'h24,
   parameter int FILT_LSB = 5,
   parameter int FILT_HI  = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              wake_act,
   input logic              pwr_en,
   input logic              sys_rst_n
);
   localparam logic [DATA_W-1:0] FILT_MASK =
      ((DATA_W'(1) << (FILT_HI + 1)) - DATA_W'(1)) & ~((DATA_W'(1) << FILT_LSB) - DATA_W'(1));

   logic cmd_hit;
   assign cmd_hit = wr_en && (wr_addr == CMD_OFS) && wr_data[0];

   AST_OFF_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n) !pwr_en |-> !sys_rst_n); // R8
   AST_CMD_POWERS_DOWN: assert property (@(posedge clk) disable iff (!rst_n) (pwr_en && sys_rst_n && cmd_hit) |=> (!pwr_en && !sys_rst_n)); // R3
   AST_RUN_STAYS_UP: assert property (@(posedge clk) disable iff (!rst_n) (pwr_en && sys_rst_n && !cmd_hit) |=> (pwr_en && sys_rst_n)); // R7
   AST_WAKE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(pwr_en) |-> $past(wake_act)); // R4
   AST_LOST_PIN_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!pwr_en && !wake_act) |=> !pwr_en); // R5
   AST_RELEASE_AFTER_POWER: assert property (@(posedge clk) disable iff (!rst_n) $rose(sys_rst_n) |-> $past(pwr_en)); // R6
   AST_FILT_FIELD_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (rd_addr == FILT_OFS) |-> ((rd_data & ~FILT_MASK) == '0)); // R2
endmodule

bind hib_wake_seq hib_wake_seq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .CMD_OFS(CMD_OFS), .FILT_OFS(FILT_OFS),
   .FILT_LSB(FILT_LSB), .FILT_HI(FILT_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .rd_addr(rd_addr), .rd_data(rd_data),
   .wake_act(wake_act), .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
);

// File: tb/hib_wake_seq_bench.sv
module hib_wake_seq_bench;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int SYNC   = 2;
   localparam int LIMIT  = 5000;
   localparam int NVEC   = 5;
   localparam int VEC_F [NVEC] = '{0, 1, 3, 0, 2};
   localparam int VEC_H [NVEC] = '{0, 2, 1, 4, 0};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [DATA_W-1:0] rd_data;
   logic              wake_n = 1'b1;
   logic              pwr_en;
   logic              sys_rst_n;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   hib_wake_seq u_hib_wake_seq (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .wake_n(wake_n), .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
   );

   function automatic int ticks(input int field);
      return (field * 32 == 0) ? 1 : field * 32;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic count_to_power(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!pwr_en && n < LIMIT);
   endtask

   task automatic count_to_release(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!sys_rst_n && n < LIMIT);
   endtask

   initial begin
      logic [DATA_W-1:0] rv;
      int n;
      int bad;
      repeat (3) @(negedge clk);
      check("R1 pwr_en in reset", pwr_en, 1);
      check("R1 sys_rst_n in reset", sys_rst_n, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 pwr_en after reset", pwr_en, 1);
      check("R1 sys_rst_n after reset", sys_rst_n, 1);
      reg_read(8'h24, rv); check("R1 filter default", rv, 32'h0000_0CC0);
      reg_read(8'h28, rv); check("R1 hold default", rv, 32'h0000_07A0);

      // R2: field masking and read map
      reg_write(8'h24, 32'hFFFF_FFFF);
      reg_write(8'h28, 32'hFFFF_FFFF);
      reg_read(8'h24, rv); check("R2 filter masked", rv, 32'h0000_FFE0);
      reg_read(8'h28, rv); check("R2 hold masked", rv, 32'h0000_0FE0);
      reg_read(8'h20, rv); check("R2 command reads zero", rv, 0);
      reg_read(8'h2C, rv); check("R2 unmapped reads zero", rv, 0);

      // R3: command with bit 0 clear is ignored
      reg_write(8'h20, 32'hFFFF_FFFE);
      check("R3 bit0 clear keeps power", pwr_en, 1);
      check("R3 bit0 clear keeps reset high", sys_rst_n, 1);

      // Vector table: R4 wake latency, R6 reset hold
      for (int i = 0; i < NVEC; i++) begin
         reg_write(8'h24, 32'(VEC_F[i] << 5));
         reg_write(8'h28, 32'(VEC_H[i] << 5));
         reg_read(8'h24, rv); check("R2 filter readback", rv, VEC_F[i] * 32);
         reg_read(8'h28, rv); check("R2 hold readback", rv, VEC_H[i] * 32);
         reg_write(8'h20, 32'h1);
         check("R3 power off after command", pwr_en, 0);
         check("R3 reset low after command", sys_rst_n, 0);
         wake_n = 1'b0;
         count_to_power(n);
         check("R4 wake latency", n, SYNC + ticks(VEC_F[i]));
         count_to_release(n);
         check("R6 reset hold length", n, ticks(VEC_H[i]));
         wake_n = 1'b1;
         repeat (4) @(negedge clk);
      end

      // R5: short pulse rejected, count restarts
      reg_write(8'h24, 32'h20);
      reg_write(8'h28, 32'h0);
      reg_write(8'h20, 32'h1);
      wake_n = 1'b0;
      repeat (20) @(negedge clk);
      wake_n = 1'b1;
      repeat (10) @(negedge clk);
      check("R5 glitch keeps power off", pwr_en, 0);
      wake_n = 1'b0;
      repeat (3) @(negedge clk);
      wake_n = 1'b1;
      repeat (6) @(negedge clk);
      check("R5 second glitch keeps power off", pwr_en, 0);
      wake_n = 1'b0;
      count_to_power(n);
      check("R5 count restarted", n, SYNC + 32);
      count_to_release(n);
      wake_n = 1'b1;

      // R7: command during filtering ignored
      reg_write(8'h20, 32'h1);
      wake_n = 1'b0;
      n = 0;
      do begin
         wr_en = (n == 5); wr_addr = 8'h20; wr_data = 32'h1;
         @(negedge clk); n++;
      end while (!pwr_en && n < LIMIT);
      wr_en = 1'b0;
      check("R7 command while filtering ignored", n, SYNC + 32);
      count_to_release(n);

      // R7: pin held while running; R9: command with pin already asserted
      bad = 0;
      repeat (40) begin
         @(negedge clk);
         if (!pwr_en || !sys_rst_n) bad++;
      end
      check("R7 pin in run ignored", bad, 0);
      reg_write(8'h20, 32'h1);
      check("R9 entry with pin asserted", pwr_en, 0);
      count_to_power(n);
      check("R9 filter starts next cycle", n, 32);
      check("R8 reset still low at power rise", sys_rst_n, 0);
      count_to_release(n);
      check("R6 zero hold releases next tick", n, 1);
      wake_n = 1'b1;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule